// File: doc/BRIEF.md
# Temperature Readout Register Bank

This block keeps the latest temperature reading of three sensing channels (remote 1, local, remote 2) and serves them through a small register read port. Each measurement arrives as a signed fixed-point value with eight integer bits and four fraction bits, plus a fault flag that marks an open or shorted sensing diode. A `meas_valid` strobe loads all three channels in parallel. On capture, the block encodes the integer part as an 8-bit whole-degree register. The fraction bits go into two extended-resolution registers.

The value stored is encoded at capture time. The `fmt_off64` input selects plain two's complement or an offset-64 code, and a faulty channel is replaced by a format-specific fault code. A reader that needs a coherent pair of whole-degree and fraction values reads an extended-resolution register first. That read freezes the whole bank: measurements that arrive while frozen are discarded. Each whole-degree register is released from its hold when it is read, and loading resumes once all three have been read.

A two-state controller drives the freeze. In state TRACK the bank accepts measurements. The transition *snapshot* (an extended-register read) moves it to HELD and marks all three whole-degree registers pending. In HELD, the transition *re-arm* (another extended-register read) marks all three pending again. The transition *release* (the read that clears the last pending register) returns it to TRACK.

Top module: `tr_readout_bank`

## Requirements
- R1: After reset, addresses 0x25, 0x26 and 0x27 read 0x80, and addresses 0x76 and 0x77 read 0x00.
- R2: With `fmt_off64` low and no fault, a captured reading shows its integer part (two's complement) at 0x25 for remote 1, 0x26 for local and 0x27 for remote 2. The four fraction bits appear at 0x76 bits 3:0 (remote 1), 0x76 bits 7:4 (local) and 0x77 bits 3:0 (remote 2), with 0x77 bits 7:4 reading zero. `rd_data` shows the addressed register in the cycle after `rd_en` is sampled.
- R3: With `fmt_off64` high and no fault, the whole-degree register holds the integer part plus 64. A sum below zero saturates to 0x00 and zeroes that channel's fraction bits.
- R4: With `fmt_off64` low, a channel whose fault flag is set at capture reads 0x80 with zero fraction bits.
- R5: With `fmt_off64` high, a channel whose fault flag is set at capture reads 0x00 with zero fraction bits.
- R6: After a read of 0x76 or 0x77, all whole-degree and fraction registers keep their values while any whole-degree register is still pending. Measurements in that period are discarded.
- R7: Reading a pending whole-degree register clears only its own pending mark. Measurements load again only after all three are cleared, and none of the measurements discarded earlier appears afterwards.
- R8: A read of 0x76 or 0x77 while the bank is held makes all three whole-degree registers pending again.
- R9: A read of any other address returns 0x00, and `rd_data` keeps its value in cycles without `rd_en`.
- R10: A measurement strobed in the same cycle as an extended-register read is discarded, and that read returns the value from before the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | Load strobe for a new set of three readings |
| meas_temp | input | 36 | Readings {remote 2, local, remote 1}, each signed 8.4 fixed point |
| meas_fault | input | 3 | Diode fault flags, bit 0 remote 1, bit 1 local, bit 2 remote 2 |
| fmt_off64 | input | 1 | 0: two's complement, 1: offset-64 encoding |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Register address |
| rd_data | output | 8 | Registered read data |

## Verification
The checker watches every cycle for the freeze rules. Stored values must not move while the controller is held. An extended read must leave all three registers pending and the controller held. A same-cycle strobe must not reach the registers. The read data must hold between reads. On every capture it also checks the fault codes of both formats. The encoding values, the saturation point and the per-field packing of the fraction registers only show in the bench's scenarios. The same is true of the fact that discarded measurements never appear after release: the bench compares reads against a model built from the requirements, under directed corners and a long seeded random mix.

// File: rtl/tr_readout_pkg.sv
package tr_readout_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 8;
    localparam int INT_W   = 8;
    localparam int FRAC_W  = 4;
    localparam int TEMP_W  = INT_W + FRAC_W;
    localparam int NUM_CH  = 3;

    localparam logic [ADDR_W-1:0] A_WHOLE0 = 8'h25;
    localparam logic [ADDR_W-1:0] A_WHOLE1 = 8'h26;
    localparam logic [ADDR_W-1:0] A_WHOLE2 = 8'h27;
    localparam logic [ADDR_W-1:0] A_FINE0  = 8'h76;
    localparam logic [ADDR_W-1:0] A_FINE1  = 8'h77;

    localparam logic [DATA_W-1:0] WHOLE_RST = 8'h80;
    localparam logic [DATA_W-1:0] FLT_TWOS  = 8'h80;
    localparam logic [DATA_W-1:0] FLT_OFF   = 8'h00;

    typedef enum logic {ST_TRACK, ST_HELD} hold_state_t;
endpackage

// File: rtl/tr_chan.sv
module tr_chan
    import tr_readout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              fault_i,
    input  logic              fmt_off64,
    output logic [INT_W-1:0]  whole_q,
    output logic [FRAC_W-1:0] fine_q
);
    localparam int SUM_W  = INT_W + 1;
    localparam int OFFSET = 1 << (INT_W - 2);

    logic [SUM_W-1:0]  off_sum;
    logic [INT_W-1:0]  whole_d;
    logic [FRAC_W-1:0] fine_d;

    assign off_sum = {temp_i[TEMP_W-1], temp_i[TEMP_W-1:FRAC_W]} + SUM_W'(OFFSET);

    always_comb begin
        whole_d = temp_i[TEMP_W-1:FRAC_W];
        fine_d  = temp_i[FRAC_W-1:0];
        if (fault_i) begin
            whole_d = fmt_off64 ? FLT_OFF : FLT_TWOS;
            fine_d  = '0;
        end else if (fmt_off64) begin
            if (off_sum[SUM_W-1]) begin
                whole_d = '0;
                fine_d  = '0;
            end else begin
                whole_d = off_sum[INT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            whole_q <= WHOLE_RST;
            fine_q  <= '0;
        end else if (cap_en) begin
            whole_q <= whole_d;
            fine_q  <= fine_d;
        end
    end
endmodule

// File: rtl/tr_hold_ctrl.sv
module tr_hold_ctrl
    import tr_readout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_valid,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              cap_en,
    output logic              held,
    output logic [NUM_CH-1:0] pend
);
    hold_state_t       state_q, state_d;
    logic [NUM_CH-1:0] pend_d;
    logic [NUM_CH-1:0] whole_hit;
    logic              fine_hit;

    assign fine_hit = rd_en && (rd_addr == A_FINE0 || rd_addr == A_FINE1);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign whole_hit[i] = rd_en && (rd_addr == A_WHOLE0 + ADDR_W'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_TRACK;
            pend    <= '0;
        end else begin
            state_q <= state_d;
            pend    <= pend_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pend_d  = pend;
        unique case (state_q)
            ST_TRACK: begin
                if (fine_hit) begin
                    state_d = ST_HELD;
                    pend_d  = '1;
                end
            end
            ST_HELD: begin
                if (fine_hit) begin
                    pend_d = '1;
                end else begin
                    pend_d = pend & ~whole_hit;
                    if (pend_d == '0) state_d = ST_TRACK;
                end
            end
            default: begin
                state_d = ST_TRACK;
                pend_d  = '0;
            end
        endcase
    end

    always_comb begin
        held   = (state_q == ST_HELD);
        cap_en = meas_valid && (state_q == ST_TRACK) && !fine_hit;
    end
endmodule

// File: rtl/tr_readout_bank.sv
module tr_readout_bank
    import tr_readout_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     meas_valid,
    input  logic [NUM_CH*TEMP_W-1:0] meas_temp,
    input  logic [NUM_CH-1:0]        meas_fault,
    input  logic                     fmt_off64,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    logic                     cap_en;
    logic                     held_w;
    logic [NUM_CH-1:0]        pend_w;
    logic [NUM_CH*INT_W-1:0]  whole_flat;
    logic [NUM_CH*FRAC_W-1:0] fine_flat;
    logic [DATA_W-1:0]        rd_mux;

    tr_hold_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .meas_valid (meas_valid),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .cap_en     (cap_en),
        .held       (held_w),
        .pend       (pend_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tr_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap_en    (cap_en),
            .temp_i    (meas_temp[i*TEMP_W +: TEMP_W]),
            .fault_i   (meas_fault[i]),
            .fmt_off64 (fmt_off64),
            .whole_q   (whole_flat[i*INT_W +: INT_W]),
            .fine_q    (fine_flat[i*FRAC_W +: FRAC_W])
        );
    end

    always_comb begin
        case (rd_addr)
            A_WHOLE0: rd_mux = whole_flat[0*INT_W +: INT_W];
            A_WHOLE1: rd_mux = whole_flat[1*INT_W +: INT_W];
            A_WHOLE2: rd_mux = whole_flat[2*INT_W +: INT_W];
            A_FINE0:  rd_mux = {fine_flat[1*FRAC_W +: FRAC_W], fine_flat[0 +: FRAC_W]};
            A_FINE1:  rd_mux = {{(DATA_W-FRAC_W){1'b0}}, fine_flat[2*FRAC_W +: FRAC_W]};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end
endmodule

// File: rtl/tr_readout_chk.sv
module tr_readout_chk
    import tr_readout_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     meas_valid,
    input logic [NUM_CH-1:0]        meas_fault,
    input logic                     fmt_off64,
    input logic                     rd_en,
    input logic [ADDR_W-1:0]        rd_addr,
    input logic [DATA_W-1:0]        rd_data,
    input logic                     cap_en,
    input logic                     held,
    input logic [NUM_CH-1:0]        pend,
    input logic [NUM_CH*INT_W-1:0]  whole_flat,
    input logic [NUM_CH*FRAC_W-1:0] fine_flat
);
    logic fine_rd;
    assign fine_rd = rd_en && (rd_addr == A_FINE0 || rd_addr == A_FINE1);

    // R6: nothing stored moves while the bank is held
    a_r6_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(whole_flat) && $stable(fine_flat)));

    // R7: held state and a non-empty pending set always agree
    always @(posedge clk) begin
        if (rst_n) begin
            a_r7_pend_matches_held: assert (held == (pend != '0));
        end
    end

    // R8: any extended read leaves all three pending
    a_r8_fine_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        fine_rd |=> (held && pend == '1));

    // R10: a strobe that meets an extended read never lands
    a_r10_same_cycle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_rd && meas_valid) |=> ($stable(whole_flat) && $stable(fine_flat)));

    // R9: read data holds between reads
    a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_flt
        // R4: fault code in two's complement
        a_r4_fault_twos: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_en && meas_fault[i] && !fmt_off64) |=>
            (whole_flat[i*INT_W +: INT_W] == FLT_TWOS && fine_flat[i*FRAC_W +: FRAC_W] == '0));
        // R5: fault code in offset-64
        a_r5_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_en && meas_fault[i] && fmt_off64) |=>
            (whole_flat[i*INT_W +: INT_W] == FLT_OFF && fine_flat[i*FRAC_W +: FRAC_W] == '0));
    end
endmodule

bind tr_readout_bank tr_readout_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .meas_valid (meas_valid),
    .meas_fault (meas_fault),
    .fmt_off64  (fmt_off64),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .cap_en     (cap_en),
    .held       (held_w),
    .pend       (pend_w),
    .whole_flat (whole_flat),
    .fine_flat  (fine_flat)
);

// File: tb/test_tr_readout_bank.sv
module test_tr_readout_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_valid = 1'b0;
    logic [35:0] meas_temp = '0;
    logic [2:0]  meas_fault = '0;
    logic        fmt_off64 = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_whole [3];
    logic [3:0] m_fine [3];
    logic [2:0] m_pend;
    logic [7:0] last_rd;

    always #4 clk = ~clk;

    tr_readout_bank i_tr_readout_bank (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_temp(meas_temp),
        .meas_fault(meas_fault), .fmt_off64(fmt_off64), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] enc_whole(logic [11:0] t, bit f, bit off);
        int s;
        if (f) return off ? 8'h00 : 8'h80;
        if (!off) return t[11:4];
        s = int'($signed(t[11:4])) + 64;
        if (s < 0) return 8'h00;
        return s[7:0];
    endfunction

    function automatic logic [3:0] enc_fine(logic [11:0] t, bit f, bit off);
        if (f) return 4'h0;
        if (off && (int'($signed(t[11:4])) + 64 < 0)) return 4'h0;
        return t[3:0];
    endfunction

    function automatic logic [7:0] model_val(logic [7:0] a);
        case (a)
            8'h25: return m_whole[0];
            8'h26: return m_whole[1];
            8'h27: return m_whole[2];
            8'h76: return {m_fine[1], m_fine[0]};
            8'h77: return {4'h0, m_fine[2]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_read(logic [7:0] a);
        if (a == 8'h76 || a == 8'h77) m_pend = 3'b111;
        else if (a >= 8'h25 && a <= 8'h27) m_pend[a - 8'h25] = 1'b0;
    endtask

    task automatic model_meas(logic [35:0] t, logic [2:0] f, bit off);
        if (m_pend == 3'b000) begin
            for (int i = 0; i < 3; i++) begin
                m_whole[i] = enc_whole(t[i*12 +: 12], f[i], off);
                m_fine[i]  = enc_fine(t[i*12 +: 12], f[i], off);
            end
        end
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_read(logic [7:0] a, string req);
        logic [7:0] e;
        e = model_val(a);
        model_read(a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rd_data, e);
        last_rd = e;
    endtask

    task automatic do_meas(logic [35:0] t, logic [2:0] f, bit off);
        model_meas(t, f, off);
        @(negedge clk);
        meas_valid = 1'b1; meas_temp = t; meas_fault = f; fmt_off64 = off;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic do_meas_with_fine(logic [35:0] t, logic [7:0] a, string req);
        logic [7:0] e;
        e = model_val(a);
        model_read(a);
        @(negedge clk);
        meas_valid = 1'b1; meas_temp = t; meas_fault = 3'b000; fmt_off64 = 1'b0;
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        meas_valid = 1'b0; rd_en = 1'b0;
        check(req, rd_data, e);
        last_rd = e;
    endtask

    task automatic read_all(string req);
        do_read(8'h76, req);
        do_read(8'h77, req);
        do_read(8'h25, req);
        do_read(8'h26, req);
        do_read(8'h27, req);
    endtask

    function automatic logic [35:0] pack3(int d0, int d1, int d2);
        logic [11:0] a, b, c;
        a = 12'(d0); b = 12'(d1); c = 12'(d2);
        return {c, b, a};
    endfunction

    initial begin
        int unused;
        unused = $urandom(32'h5EED_0C1A);
        for (int i = 0; i < 3; i++) begin
            m_whole[i] = 8'h80;
            m_fine[i] = 4'h0;
        end
        m_pend = 3'b000;
        last_rd = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values, MSBs first, then extended (which holds), then release
        do_read(8'h25, "R1");
        do_read(8'h26, "R1");
        do_read(8'h27, "R1");
        do_read(8'h76, "R1");
        do_read(8'h77, "R1");
        do_read(8'h25, "R1");
        do_read(8'h26, "R1");
        do_read(8'h27, "R1");

        // R2: two's complement, fraction packing
        do_meas(pack3(25*16+9, -3*16+5, 100*16+15), 3'b000, 1'b0);
        read_all("R2");

        // R3: offset-64 with saturation and the top end
        do_meas(pack3(-100*16+7, 127*16+3, 8), 3'b000, 1'b1);
        read_all("R3");
        do_meas(pack3(-64*16+2, -65*16+15, -128*16), 3'b000, 1'b1);
        read_all("R3");

        // R4 and R5: fault codes per format
        do_meas(pack3(40*16+3, 41*16+4, 42*16+5), 3'b101, 1'b0);
        read_all("R4");
        do_meas(pack3(40*16+3, 41*16+4, 42*16+5), 3'b011, 1'b1);
        read_all("R5");

        // R6 / R7: hold, drop, per-register release, no queueing
        do_meas(pack3(10*16, 20*16, 30*16), 3'b000, 1'b0);
        do_read(8'h76, "R6");
        do_meas(pack3(-5*16, -6*16, -7*16), 3'b000, 1'b0);
        do_read(8'h25, "R6");
        do_meas(pack3(-8*16, -9*16, -10*16), 3'b000, 1'b0);
        do_read(8'h26, "R7");
        do_read(8'h77, "R6");
        do_read(8'h26, "R7");
        do_read(8'h25, "R7");
        do_read(8'h27, "R7");
        do_read(8'h25, "R7");
        do_read(8'h27, "R7");
        do_meas(pack3(55*16+1, 56*16+2, 57*16+3), 3'b000, 1'b0);
        do_read(8'h25, "R7");

        // R8: re-arm while held
        do_read(8'h77, "R8");
        do_read(8'h25, "R8");
        do_read(8'h26, "R8");
        do_read(8'h76, "R8");
        do_read(8'h27, "R8");
        do_meas(pack3(1*16, 2*16, 3*16), 3'b000, 1'b0);
        do_read(8'h25, "R8");
        do_read(8'h26, "R8");
        do_meas(pack3(4*16, 5*16, 6*16), 3'b000, 1'b0);
        do_read(8'h26, "R8");

        // R9: unmapped address and hold without strobe
        do_read(8'h40, "R9");
        do_read(8'h25, "R9");
        repeat (3) @(negedge clk);
        check("R9", rd_data, last_rd);
        do_read(8'hFF, "R9");

        // R10: strobe in the same cycle as an extended read
        do_meas_with_fine(pack3(77*16, 78*16, 79*16), 8'h76, "R10");
        do_read(8'h25, "R10");
        do_read(8'h26, "R10");
        do_read(8'h27, "R10");
        do_read(8'h26, "R10");

        // R2: seeded random mix of measurements and reads
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) begin
                logic [2:0] f;
                f = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
                do_meas({12'($urandom), 12'($urandom), 12'($urandom)}, f, 1'($urandom));
            end else begin
                logic [7:0] a;
                case ($urandom_range(0, 5))
                    0: a = 8'h25;
                    1: a = 8'h26;
                    2: a = 8'h27;
                    3: a = 8'h76;
                    4: a = 8'h77;
                    default: a = 8'($urandom);
                endcase
                do_read(a, "R2");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule